// File: doc/BRIEF.md
# Local Bus Arbiter with Implied-Mastership Resolution

This block decides, cycle by cycle, which of two masters may drive a synchronous local bus: a cached processor and one alternate master such as a DMA-capable bridge or card. The processor side speaks through three active-low pins: request, busy and transfer-start. The alternate master speaks through an active-high request and busy pair, and receives a grant.

The difficult case is the clock right after the processor lets go of both request and busy. In that clock the processor may still launch one more transfer without asking. The arbiter does not hand the bus over blindly, and it does not hold the bus for an idle processor either. It spends exactly one probe clock watching transfer-start. During that clock neither master holds a grant. The alternate master is told through an early-warning output that it may prepare to take over, but it must not drive the bus.

- If the processor starts a cycle in the probe clock, it keeps the bus until the cycle-end pulse.
- Otherwise the alternate master is granted on the next edge.

When nobody asks for the bus, it rests with the processor. All handshake pins are plain control signals: there is no data stream here, so no valid/ready back-pressure applies.

Top module: `lbarb_top`

## Requirements
- R1: During and after reset, before any request: `cpu_gnt`=1, `alt_gnt`=0, `alt_early`=0, `owner`=2'b00. Owner codes are 00 processor, 01 probe, 10 alternate, 11 implied processor cycle.
- R2: `cpu_gnt` and `alt_gnt` are never both 1 in the same cycle.
- R3: While `cpu_req_n` or `cpu_busy_n` is low, a clear `alt_gnt` stays clear on the next edge. This includes a processor that re-asserts its request during the probe clock, which returns `owner` to 00.
- R4: With the processor owning the bus, an edge that samples `cpu_req_n`=1, `cpu_busy_n`=1 and `alt_req`=1 enters the probe state. In the probe state `owner`=01, `alt_early`=1 and both grants are 0.
- R5: In the probe state, `cpu_start_n`=0 moves to `owner`=11 with `cpu_gnt`=1 and `alt_gnt`=0. That state is held until an edge samples `cpu_cyc_end`=1, which returns `owner` to 00.
- R6: In the probe state, with `cpu_start_n`=1, request and busy still high and `alt_req`=1, the next edge sets `alt_gnt`=1 and `owner`=10.
- R7: With the processor idle (request, busy and transfer-start all high and no implied cycle pending), `alt_gnt` rises no more than 3 clock edges after `alt_req` is first sampled high.
- R8: While `alt_gnt`=1 and `alt_busy`=1, `alt_gnt` stays 1, whatever the processor pins do.
- R9: An edge that samples `alt_gnt`=1, `alt_busy`=0 and `cpu_req_n`=0 sets `cpu_gnt`=1 and clears `alt_gnt`.
- R10: With no request from either side, the bus parks on the processor (`owner`=00, `cpu_gnt`=1). A probe whose `alt_req` drops goes back to the processor. So does an alternate tenure that ends with `alt_busy`=0 and `alt_req`=0.
- R11: After an implied cycle ends, a still-pending alternate request is granted through a fresh probe. The processor's silence does not keep the bus locked.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_n | input | 1 | Processor bus request, active low |
| cpu_busy_n | input | 1 | Processor bus busy (holding ownership), active low |
| cpu_start_n | input | 1 | Processor transfer start, active low |
| cpu_cyc_end | input | 1 | One-clock pulse marking the end of the current processor transfer |
| alt_req | input | 1 | Alternate master request |
| alt_busy | input | 1 | Alternate master holding the bus |
| cpu_gnt | output | 1 | Processor bus grant (registered) |
| alt_gnt | output | 1 | Alternate master grant (registered) |
| alt_early | output | 1 | Probe clock: alternate may prepare but must not drive |
| owner | output | 2 | Current owner code (00 cpu, 01 probe, 10 alt, 11 implied) |

## Verification
The bench leads the processor into the release clock and then starts a transfer exactly in the probe window. An arbiter that skipped the probe would grant the alternate master on top of an active processor. It then holds the implied cycle open across several clocks before the cycle-end pulse, and requests again afterwards. A design that parked on the silent processor would never raise `alt_gnt` there. Further sequences cover a processor that re-requests mid-probe, an alternate master that withdraws mid-probe, and busy release with and without a waiting processor. Wrong exits from these would show up as a stuck or misdirected grant.

// File: rtl/lbarb_pkg.sv
package lbarb_pkg;
  typedef enum logic [1:0] {
    OWN_CPU   = 2'b00,
    OWN_PROBE = 2'b01,
    OWN_ALT   = 2'b10,
    OWN_IMPL  = 2'b11
  } owner_e;

  localparam int unsigned OWNER_W = 2;
endpackage

// File: rtl/lbarb_cpu_sense.sv
module lbarb_cpu_sense (
  input  logic cpu_req_n,
  input  logic cpu_busy_n,
  input  logic cpu_start_n,
  output logic cpu_wants,
  output logic cpu_released,
  output logic cpu_starts
);
  // Active-low pins folded into positive-sense decisions.
  always_comb begin
    cpu_wants    = !cpu_req_n || !cpu_busy_n;
    cpu_released = cpu_req_n && cpu_busy_n;
    cpu_starts   = !cpu_start_n;
  end
endmodule

// File: rtl/lbarb_fsm.sv
module lbarb_fsm
  import lbarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cpu_wants,
  input  logic   cpu_released,
  input  logic   cpu_starts,
  input  logic   cpu_cyc_end,
  input  logic   alt_req,
  input  logic   alt_busy,
  output owner_e state_q,
  output owner_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      OWN_CPU: begin
        if (cpu_released && alt_req) state_d = OWN_PROBE;
      end
      OWN_PROBE: begin
        // Transfer start wins: the processor still owns this cycle.
        if (cpu_starts)    state_d = OWN_IMPL;
        else if (cpu_wants) state_d = OWN_CPU;
        else if (alt_req)   state_d = OWN_ALT;
        else                state_d = OWN_CPU;
      end
      OWN_IMPL: begin
        if (cpu_cyc_end) state_d = OWN_CPU;
      end
      OWN_ALT: begin
        if (!alt_busy && (!alt_req || cpu_wants)) state_d = OWN_CPU;
      end
      default: state_d = OWN_CPU;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= OWN_CPU;
    else        state_q <= state_d;
  end

  AST_IMPL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_IMPL && !cpu_cyc_end) |=> (state_q == OWN_IMPL)); // R5
  AST_PROBE_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == OWN_PROBE) |=> (state_q != OWN_PROBE)); // R4
endmodule

// File: rtl/lbarb_grant_reg.sv
module lbarb_grant_reg
  import lbarb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  owner_e state_d,
  output logic   cpu_gnt,
  output logic   alt_gnt,
  output logic   alt_early
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_gnt   <= 1'b1;
      alt_gnt   <= 1'b0;
      alt_early <= 1'b0;
    end else begin
      cpu_gnt   <= (state_d == OWN_CPU) || (state_d == OWN_IMPL);
      alt_gnt   <= (state_d == OWN_ALT);
      alt_early <= (state_d == OWN_PROBE);
    end
  end

  AST_PROBE_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    alt_early |-> (!cpu_gnt && !alt_gnt)); // R4
endmodule

// File: rtl/lbarb_top.sv
module lbarb_top
  import lbarb_pkg::*;
#(
  parameter int unsigned LAT_MAX = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_req_n,
  input  logic               cpu_busy_n,
  input  logic               cpu_start_n,
  input  logic               cpu_cyc_end,
  input  logic               alt_req,
  input  logic               alt_busy,
  output logic               cpu_gnt,
  output logic               alt_gnt,
  output logic               alt_early,
  output logic [OWNER_W-1:0] owner
);
  localparam int unsigned CNT_W = $clog2(LAT_MAX + 2);

  logic   cpu_wants, cpu_released, cpu_starts;
  owner_e state_q, state_d;

  lbarb_cpu_sense u_sense (
    .cpu_req_n    (cpu_req_n),
    .cpu_busy_n   (cpu_busy_n),
    .cpu_start_n  (cpu_start_n),
    .cpu_wants    (cpu_wants),
    .cpu_released (cpu_released),
    .cpu_starts   (cpu_starts)
  );

  lbarb_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .cpu_wants    (cpu_wants),
    .cpu_released (cpu_released),
    .cpu_starts   (cpu_starts),
    .cpu_cyc_end  (cpu_cyc_end),
    .alt_req      (alt_req),
    .alt_busy     (alt_busy),
    .state_q      (state_q),
    .state_d      (state_d)
  );

  lbarb_grant_reg u_gnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .state_d   (state_d),
    .cpu_gnt   (cpu_gnt),
    .alt_gnt   (alt_gnt),
    .alt_early (alt_early)
  );

  assign owner = state_q;

  // Wait-time observer for the idle-processor grant bound.
  logic [CNT_W-1:0] wait_cnt;
  logic             idle_wait;
  assign idle_wait = alt_req && !alt_gnt && cpu_released && !cpu_starts
                     && (state_q != OWN_IMPL);

  always_ff @(posedge clk) begin
    if (!rst_n)         wait_cnt <= '0;
    else if (idle_wait) wait_cnt <= wait_cnt + 1'b1;
    else                wait_cnt <= '0;
  end

  AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cpu_gnt, alt_gnt})); // R2
  AST_CPU_BLOCKS_ALT: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wants && !alt_gnt) |=> !alt_gnt); // R3
  AST_IMPL_KEEPS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_early && cpu_starts) |=> (cpu_gnt && !alt_gnt)); // R5
  AST_GRANT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= CNT_W'(LAT_MAX)); // R7
  AST_ALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_gnt && alt_busy) |=> alt_gnt); // R8
  AST_REGRANT_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_gnt && !alt_busy && !cpu_req_n) |=> (cpu_gnt && !alt_gnt)); // R9
  AST_PARK_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_gnt && !alt_req && state_q == OWN_CPU) |=> cpu_gnt); // R10
endmodule

// File: tb/lbarb_top_bench.sv
module lbarb_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cpu_req_n = 1'b1, cpu_busy_n = 1'b1, cpu_start_n = 1'b1, cpu_cyc_end = 1'b0;
  logic alt_req = 1'b0, alt_busy = 1'b0;
  logic cpu_gnt, alt_gnt, alt_early;
  logic [1:0] owner;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic       cg;
    logic       ag;
    logic       ae;
    logic [1:0] ow;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  lbarb_top u_lbarb_top (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_n(cpu_req_n), .cpu_busy_n(cpu_busy_n), .cpu_start_n(cpu_start_n),
    .cpu_cyc_end(cpu_cyc_end), .alt_req(alt_req), .alt_busy(alt_busy),
    .cpu_gnt(cpu_gnt), .alt_gnt(alt_gnt), .alt_early(alt_early), .owner(owner)
  );

  task automatic compare(input exp_t e);
    checks++;
    if ({cpu_gnt, alt_gnt, alt_early, owner} !== {e.cg, e.ag, e.ae, e.ow}) begin
      errors++;
      $display("FAIL %s: got cg=%b ag=%b ae=%b own=%b expected cg=%b ag=%b ae=%b own=%b",
               e.tag, cpu_gnt, alt_gnt, alt_early, owner, e.cg, e.ag, e.ae, e.ow);
    end
  endtask

  // Driver: apply inputs away from the edge, queue the result due after the next edge.
  task automatic step(input logic br, input logic bb, input logic ts, input logic ce,
                      input logic ar, input logic ab,
                      input logic cg, input logic ag, input logic ae,
                      input logic [1:0] ow, input string tag);
    exp_t e;
    @(negedge clk);
    cpu_req_n = br; cpu_busy_n = bb; cpu_start_n = ts; cpu_cyc_end = ce;
    alt_req = ar; alt_busy = ab;
    e.cg = cg; e.ag = ag; e.ae = ae; e.ow = ow; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: sample 2 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  initial begin
    exp_t r;
    repeat (3) @(posedge clk);
    #2;
    r.cg = 1; r.ag = 0; r.ae = 0; r.ow = 2'b00; r.tag = "R1 reset";
    compare(r);
    @(negedge clk); rst_n = 1'b1;
    //    br bb ts ce ar ab   cg ag ae own
    step(1, 1, 1, 0, 0, 0,   1, 0, 0, 2'b00, "R1 idle after reset");
    step(1, 1, 1, 0, 0, 0,   1, 0, 0, 2'b00, "R10 park");
    step(0, 0, 1, 0, 1, 0,   1, 0, 0, 2'b00, "R3 cpu request blocks alt");
    step(1, 0, 1, 0, 1, 0,   1, 0, 0, 2'b00, "R3 cpu busy blocks alt");
    step(1, 1, 1, 0, 1, 0,   0, 0, 1, 2'b01, "R4 probe");
    step(1, 1, 1, 0, 1, 0,   0, 1, 0, 2'b10, "R6 alt granted");
    step(0, 1, 1, 0, 1, 1,   0, 1, 0, 2'b10, "R8 alt busy holds");
    step(0, 0, 1, 0, 0, 1,   0, 1, 0, 2'b10, "R8 alt busy holds vs cpu");
    step(0, 1, 1, 0, 0, 0,   1, 0, 0, 2'b00, "R9 regrant cpu");
    step(1, 1, 1, 0, 1, 0,   0, 0, 1, 2'b01, "R4 probe again");
    step(1, 1, 0, 0, 1, 0,   1, 0, 0, 2'b11, "R5 implied cycle");
    step(1, 1, 1, 0, 1, 0,   1, 0, 0, 2'b11, "R5 implied held");
    step(1, 1, 1, 0, 1, 0,   1, 0, 0, 2'b11, "R5 implied held 2");
    step(1, 1, 1, 1, 1, 0,   1, 0, 0, 2'b00, "R5 implied ends");
    step(1, 1, 1, 0, 1, 0,   0, 0, 1, 2'b01, "R11 fresh probe");
    step(1, 1, 1, 0, 1, 0,   0, 1, 0, 2'b10, "R11 alt not locked out");
    step(1, 1, 1, 0, 0, 0,   1, 0, 0, 2'b00, "R10 alt done parks cpu");
    step(1, 1, 1, 0, 1, 0,   0, 0, 1, 2'b01, "R4 probe withdraw");
    step(1, 1, 1, 0, 0, 0,   1, 0, 0, 2'b00, "R10 alt withdraws");
    step(1, 1, 1, 0, 1, 0,   0, 0, 1, 2'b01, "R4 probe re-request");
    step(0, 1, 1, 0, 1, 0,   1, 0, 0, 2'b00, "R3 cpu reclaims in probe");
    step(0, 1, 1, 0, 1, 0,   1, 0, 0, 2'b00, "R3 cpu keeps bus");
    step(1, 1, 1, 0, 0, 0,   1, 0, 0, 2'b00, "R7 idle start");
    step(1, 1, 1, 0, 1, 0,   0, 0, 1, 2'b01, "R7 edge 1");
    step(1, 1, 1, 0, 1, 0,   0, 1, 0, 2'b10, "R7 granted within bound");
    step(1, 1, 1, 0, 1, 0,   0, 1, 0, 2'b10, "R2 alt keeps, no cpu");
    step(1, 1, 1, 0, 0, 0,   1, 0, 0, 2'b00, "R10 release to park");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule